// File: doc/BRIEF.md
# Serial Receiver with Software Flow-Control Recognition

This block receives asynchronous serial characters from a single line. It samples the line with a tick that runs at sixteen times the bit rate. Each character may have five to eight data bits, with even, odd or no parity. Every received character is stored with its error flags in a show-ahead receive queue. The host drains the queue one entry at a time.

While receiving, the block compares each clean character against programmable pause and resume codes. These codes are used either singly or as back-to-back pairs. A recognised pause code raises `tx_pause` toward a companion transmitter, and a recognised resume code clears it. Flow-control codes that are recognised are consumed and never queued. A programmable special code is queued as normal data and also reported by a one-cycle pulse. A line held low for a whole character is reported as a break, and is queued as a single entry.

Top module: `uart_rx_swflow`

## Requirements
- R1: After synchronous reset the queue is empty, `rx_level` is 0 and `tx_pause` is 0.
- R2: Characters are received LSB first. The data length code `cfg_len` selects 0=5, 1=6, 2=7 or 3=8 data bits. Unused upper bits of `rd_data` read 0.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_odd`=0 selects even parity and 1 selects odd parity. A mismatch sets `rd_perr` on that entry.
- R4: A stop bit sampled low on a character that holds at least one 1 bit is queued with `rd_ferr`=1 and its data intact.
- R5: A low pulse that has ended by the 8th tick after it was first seen is rejected as a glitch, and nothing is queued.
- R6: A line that stays low through all data, parity and stop positions is queued once as data 0 with `rd_brk`=1, `rd_perr`=0 and `rd_ferr`=0, and `break_hit` pulses once. Reception resumes only after the line returns high.
- R7: With `cfg_flow_en`=1 and `cfg_pair`=0, a clean character equal to `cfg_xoff1` sets `tx_pause` and a clean character equal to `cfg_xon1` clears it. Neither is queued. If both codes are equal, pause wins. A character with a parity or framing error is never treated as a flow code.
- R8: With `cfg_pair`=1, pause needs `cfg_xoff1` followed directly by `cfg_xoff2`, and resume needs `cfg_xon1` followed directly by `cfg_xon2`. When the second character does not complete the pair, the held first character is queued and the second is evaluated afresh.
- R9: A clean queued character equal to `cfg_special` pulses `special_hit` for one cycle and is still queued. `special_hit` and `break_hit` never pulse together.
- R10: With `cfg_flow_en`=0 every character is queued and `tx_pause` keeps its value.
- R11: While `rx_en`=0 the line is ignored and nothing is queued. A character begun before disabling is abandoned.
- R12: The queue keeps arrival order and shows its head on the read outputs. A character arriving when the queue is full is dropped. A read of an empty queue is ignored. `rx_level` never exceeds the depth and changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| tick16 | input | 1 | Oversampling tick, OSR per bit |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length code (0..3 = 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_flow_en | input | 1 | Enable flow-code recognition |
| cfg_pair | input | 1 | 1 = two-character flow codes |
| cfg_xon1 | input | 8 | Resume code, first character |
| cfg_xon2 | input | 8 | Resume code, second character |
| cfg_xoff1 | input | 8 | Pause code, first character |
| cfg_xoff2 | input | 8 | Pause code, second character |
| cfg_special | input | 8 | Special code to report |
| rd_en | input | 1 | Pop the queue head |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry is a break |
| rx_empty | output | 1 | Queue empty |
| rx_level | output | $clog2(FIFO_DEPTH+1) | Entries held |
| tx_pause | output | 1 | Request to pause the transmitter |
| special_hit | output | 1 | One-cycle pulse on a special code |
| break_hit | output | 1 | One-cycle pulse on a break |

## Verification
The bench builds the block with OSR=16 and FIFO_DEPTH=8. The tick fires every second clock, so one bit lasts 32 clocks. The shallow queue lets a ten-character burst reach the full state and show the drop of later arrivals. The same burst then drains to show the ignored read from an empty queue. The default 16x oversampling keeps the mid-bit start check, glitch rejection and break timing at their real proportions.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_char_t;

    localparam int CHAR_W = $bits(rx_char_t);

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_DATA,
        FS_PAR,
        FS_STOP,
        FS_WAIT_HI
    } frame_state_t;

    // index of the last data bit for a length code (5..8 bits)
    function automatic logic [2:0] last_bit(input logic [1:0] code);
        return {1'b1, code};
    endfunction

    // expected parity bit; upper unused data bits are zero
    function automatic logic par_expect(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    output logic       out_valid,
    output rx_char_t   out_char
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    logic [1:0]     sync_q;
    logic           rx_s;
    frame_state_t   state;
    logic [CW-1:0]  cnt;
    logic [2:0]     idx;
    logic [7:0]     shreg;
    logic           any_one;
    logic           perr_q;

    assign rx_s = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state     <= FS_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            any_one   <= 1'b0;
            perr_q    <= 1'b0;
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (tick) begin
                case (state)
                    FS_IDLE: begin
                        if (!rx_s) begin
                            state <= FS_START;
                            cnt   <= '0;
                        end
                    end
                    FS_START: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (rx_s) begin
                                state <= FS_IDLE;
                            end else begin
                                state   <= FS_DATA;
                                idx     <= '0;
                                shreg   <= '0;
                                any_one <= 1'b0;
                                perr_q  <= 1'b0;
                            end
                        end
                    end
                    FS_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            cnt        <= '0;
                            shreg[idx] <= rx_s;
                            any_one    <= any_one | rx_s;
                            idx        <= idx + 1'b1;
                            if (idx == last_bit(cfg_len))
                                state <= cfg_par_en ? FS_PAR : FS_STOP;
                        end
                    end
                    FS_PAR: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            perr_q  <= (rx_s != par_expect(shreg, cfg_par_odd));
                            any_one <= any_one | rx_s;
                            state   <= FS_STOP;
                        end
                    end
                    FS_STOP: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            cnt       <= '0;
                            out_valid <= 1'b1;
                            if (rx_s) begin
                                out_char <= '{brk: 1'b0, ferr: 1'b0, perr: perr_q, data: shreg};
                                state    <= FS_IDLE;
                            end else if (!any_one) begin
                                out_char <= '{brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: 8'h00};
                                state    <= FS_WAIT_HI;
                            end else begin
                                out_char <= '{brk: 1'b0, ferr: 1'b1, perr: perr_q, data: shreg};
                                state    <= FS_WAIT_HI;
                            end
                        end
                    end
                    FS_WAIT_HI: begin
                        if (rx_s) state <= FS_IDLE;
                    end
                    default: state <= FS_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/srx_match.sv
module srx_match
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  rx_char_t   in_char,
    input  logic       cfg_flow_en,
    input  logic       cfg_pair,
    input  logic [7:0] cfg_xon1,
    input  logic [7:0] cfg_xon2,
    input  logic [7:0] cfg_xoff1,
    input  logic [7:0] cfg_xoff2,
    input  logic [7:0] cfg_special,
    output logic       push_valid,
    output rx_char_t   push_char,
    output logic       tx_pause,
    output logic       special_hit,
    output logic       break_hit
);
    logic     held_v, held_off;
    rx_char_t held_c;
    logic     defer_v;
    rx_char_t defer_c;

    logic     cand_v, cand_ok, pair_done, first_hit;
    rx_char_t cand;

    always_comb begin
        cand_v    = defer_v | in_valid;
        cand      = defer_v ? defer_c : in_char;
        cand_ok   = !(cand.brk | cand.ferr | cand.perr);
        pair_done = cfg_flow_en && cand_ok &&
                    (held_off ? (cand.data == cfg_xoff2) : (cand.data == cfg_xon2));
        first_hit = cfg_flow_en && cand_ok &&
                    ((cand.data == cfg_xoff1) || (cand.data == cfg_xon1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v      <= 1'b0;
            held_off    <= 1'b0;
            held_c      <= '0;
            defer_v     <= 1'b0;
            defer_c     <= '0;
            push_valid  <= 1'b0;
            push_char   <= '0;
            tx_pause    <= 1'b0;
            special_hit <= 1'b0;
            break_hit   <= 1'b0;
        end else begin
            push_valid  <= 1'b0;
            special_hit <= 1'b0;
            break_hit   <= 1'b0;
            defer_v     <= 1'b0;
            if (cand_v) begin
                if (held_v) begin
                    held_v <= 1'b0;
                    if (pair_done) begin
                        tx_pause <= held_off;
                    end else begin
                        push_valid  <= 1'b1;
                        push_char   <= held_c;
                        special_hit <= (held_c.data == cfg_special);
                        defer_v     <= 1'b1;
                        defer_c     <= cand;
                    end
                end else if (first_hit) begin
                    if (cfg_pair) begin
                        held_v   <= 1'b1;
                        held_off <= (cand.data == cfg_xoff1);
                        held_c   <= cand;
                    end else begin
                        tx_pause <= (cand.data == cfg_xoff1);
                    end
                end else begin
                    push_valid  <= 1'b1;
                    push_char   <= cand;
                    special_hit <= cand_ok && (cand.data == cfg_special);
                    break_hit   <= cand.brk;
                end
            end
        end
    end

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [W-1:0]                 wr_data,
    input  logic                         rd_en,
    output logic [W-1:0]                 rd_data,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [LW-1:0] count;
    logic          do_wr, do_rd;

    assign do_wr   = wr_en && (count != LW'(DEPTH));
    assign do_rd   = rd_en && (count != '0);
    assign rd_data = mem[rptr];
    assign empty   = (count == '0);
    assign level   = count;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_swflow.sv
module uart_rx_swflow
    import srx_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int FIFO_DEPTH = 64
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              rx_en,
    input  logic                              tick16,
    input  logic                              rxd,
    input  logic [1:0]                        cfg_len,
    input  logic                              cfg_par_en,
    input  logic                              cfg_par_odd,
    input  logic                              cfg_flow_en,
    input  logic                              cfg_pair,
    input  logic [7:0]                        cfg_xon1,
    input  logic [7:0]                        cfg_xon2,
    input  logic [7:0]                        cfg_xoff1,
    input  logic [7:0]                        cfg_xoff2,
    input  logic [7:0]                        cfg_special,
    input  logic                              rd_en,
    output logic [7:0]                        rd_data,
    output logic                              rd_perr,
    output logic                              rd_ferr,
    output logic                              rd_brk,
    output logic                              rx_empty,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]   rx_level,
    output logic                              tx_pause,
    output logic                              special_hit,
    output logic                              break_hit
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic     fr_valid, push_valid;
    rx_char_t fr_char, push_char, head;

    srx_framer #(.OSR(OSR)) u_framer (
        .clk(clk), .rst(rst), .enable(rx_en), .tick(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .out_valid(fr_valid), .out_char(fr_char)
    );

    srx_match u_match (
        .clk(clk), .rst(rst), .in_valid(fr_valid), .in_char(fr_char),
        .cfg_flow_en(cfg_flow_en), .cfg_pair(cfg_pair),
        .cfg_xon1(cfg_xon1), .cfg_xon2(cfg_xon2),
        .cfg_xoff1(cfg_xoff1), .cfg_xoff2(cfg_xoff2),
        .cfg_special(cfg_special),
        .push_valid(push_valid), .push_char(push_char),
        .tx_pause(tx_pause), .special_hit(special_hit), .break_hit(break_hit)
    );

    srx_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_en(push_valid), .wr_data(push_char),
        .rd_en(rd_en), .rd_data(head),
        .empty(rx_empty), .level(rx_level)
    );

    assign rd_data = head.data;
    assign rd_perr = head.perr;
    assign rd_ferr = head.ferr;
    assign rd_brk  = head.brk;

endmodule

// File: rtl/uart_rx_swflow_chk.sv
module uart_rx_swflow_chk #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic             rx_empty,
    input logic [LVL_W-1:0] rx_level,
    input logic             cfg_flow_en,
    input logic             tx_pause,
    input logic             special_hit,
    input logic             break_hit
);
    // R1: first cycle after reset shows an empty queue and no pause
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rx_empty && !tx_pause));

    // R12: level never above depth
    p_level_cap_r12: assert property (@(posedge clk) disable iff (rst)
        rx_level <= LVL_W'(DEPTH));

    // R12: level moves by at most one per cycle
    p_level_step_r12: assert property (@(posedge clk) disable iff (rst)
        (rx_level == $past(rx_level)) || (rx_level == $past(rx_level) + 1'b1) ||
        (rx_level + 1'b1 == $past(rx_level)));

    // R12: a full queue stays full until read
    p_full_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (rx_level == LVL_W'(DEPTH) && !rd_en) |=> (rx_level == LVL_W'(DEPTH)));

    // R10: pause output frozen while recognition is off
    p_flow_off_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_flow_en |=> $stable(tx_pause));

    // R9: special and break pulses are exclusive
    p_hits_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(special_hit && break_hit));
endmodule

bind uart_rx_swflow uart_rx_swflow_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rx_empty(rx_empty), .rx_level(rx_level),
    .cfg_flow_en(cfg_flow_en), .tx_pause(tx_pause),
    .special_hit(special_hit), .break_hit(break_hit)
);

// File: tb/uart_rx_swflow_bench.sv
module uart_rx_swflow_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int LVL_W      = $clog2(DEPTH + 1);
    localparam int BIT_CLKS   = 32;   // 16 ticks, one tick every 2 clocks

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_en = 1'b1;
    logic tick16 = 1'b0;
    logic rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic cfg_flow_en = 1'b0, cfg_pair = 1'b0;
    logic [7:0] cfg_xon1 = 8'h11, cfg_xon2 = 8'h91, cfg_xoff1 = 8'h13, cfg_xoff2 = 8'h93;
    logic [7:0] cfg_special = 8'h7E;
    logic rd_en = 1'b0;
    logic [7:0] rd_data;
    logic rd_perr, rd_ferr, rd_brk, rx_empty;
    logic [LVL_W-1:0] rx_level;
    logic tx_pause, special_hit, break_hit;

    int n_checks = 0;
    int n_bad = 0;
    int n_special = 0;
    int n_break = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        tick16 <= ~tick16;
        cycles <= cycles + 1;
    end

    always @(negedge clk) begin
        if (special_hit) n_special = n_special + 1;
        if (break_hit)   n_break   = n_break + 1;
    end

    uart_rx_swflow #(.OSR(16), .FIFO_DEPTH(DEPTH)) u_uart_rx_swflow (
        .clk(clk), .rst(rst), .rx_en(rx_en), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_flow_en(cfg_flow_en), .cfg_pair(cfg_pair),
        .cfg_xon1(cfg_xon1), .cfg_xon2(cfg_xon2),
        .cfg_xoff1(cfg_xoff1), .cfg_xoff2(cfg_xoff2),
        .cfg_special(cfg_special), .rd_en(rd_en),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
        .rx_empty(rx_empty), .rx_level(rx_level), .tx_pause(tx_pause),
        .special_hit(special_hit), .break_hit(break_hit)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one frame using current cfg; flip inverts parity bit; stopv is the stop level
    task automatic send(input logic [7:0] d, input bit flip, input bit stopv);
        int nb;
        bit p;
        nb = int'(cfg_len) + 5;
        p = 1'b0;
        @(negedge clk);
        rxd = 1'b0;
        idle(BIT_CLKS);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            p = p ^ d[i];
            idle(BIT_CLKS);
        end
        if (cfg_par_en) begin
            rxd = p ^ cfg_par_odd ^ flip;
            idle(BIT_CLKS);
        end
        rxd = stopv;
        idle(BIT_CLKS);
        rxd = 1'b1;
        idle(BIT_CLKS);
    endtask

    task automatic pop(input string req, input logic [7:0] d,
                       input bit pe, input bit fe, input bit bk);
        chk({req, " not empty"}, int'(rx_empty), 0);
        chk({req, " data"}, int'(rd_data), int'(d));
        chk({req, " perr"}, int'(rd_perr), int'(pe));
        chk({req, " ferr"}, int'(rd_ferr), int'(fe));
        chk({req, " brk"}, int'(rd_brk), int'(bk));
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 empty", int'(rx_empty), 1);
        chk("R1 level", int'(rx_level), 0);
        chk("R1 pause", int'(tx_pause), 0);
    endtask

    task automatic t_frames();
        cfg_len = 2'd3; cfg_par_en = 1'b0;
        send(8'hA5, 0, 1);
        send(8'h3C, 0, 1);
        chk("R12 level two", int'(rx_level), 2);
        pop("R2 8N1 first", 8'hA5, 0, 0, 0);
        pop("R12 order second", 8'h3C, 0, 0, 0);
        cfg_len = 2'd0;
        send(8'h15, 0, 1);
        pop("R2 5-bit", 8'h15, 0, 0, 0);
        cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send(8'h5A, 0, 1);
        pop("R3 7E1 good", 8'h5A, 0, 0, 0);
        cfg_len = 2'd3; cfg_par_odd = 1'b1;
        send(8'h3C, 0, 1);
        pop("R3 8O1 good", 8'h3C, 0, 0, 0);
        send(8'h3D, 1, 1);
        pop("R3 8O1 bad", 8'h3D, 1, 0, 0);
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    endtask

    task automatic t_ferr();
        send(8'h81, 0, 0);
        pop("R4 framing", 8'h81, 0, 1, 0);
        send(8'h42, 0, 1);
        pop("R4 after framing", 8'h42, 0, 0, 0);
    endtask

    task automatic t_glitch();
        @(negedge clk);
        rxd = 1'b0;
        idle(6);
        rxd = 1'b1;
        idle(12 * BIT_CLKS);
        chk("R5 glitch ignored", int'(rx_level), 0);
    endtask

    task automatic t_break();
        int b0;
        b0 = n_break;
        cfg_len = 2'd2; cfg_par_en = 1'b1;
        @(negedge clk);
        rxd = 1'b0;
        idle(14 * BIT_CLKS);
        rxd = 1'b1;
        idle(2 * BIT_CLKS);
        chk("R6 single entry", int'(rx_level), 1);
        chk("R6 pulse once", n_break - b0, 1);
        pop("R6 break entry", 8'h00, 0, 0, 1);
        send(8'h33, 0, 1);
        pop("R6 resume", 8'h33, 0, 0, 0);
        cfg_len = 2'd3; cfg_par_en = 1'b0;
    endtask

    task automatic t_single();
        cfg_flow_en = 1'b1; cfg_pair = 1'b0;
        send(8'h13, 0, 1);
        chk("R7 pause set", int'(tx_pause), 1);
        chk("R7 xoff not queued", int'(rx_level), 0);
        send(8'h41, 0, 1);
        chk("R7 pause held", int'(tx_pause), 1);
        send(8'h11, 0, 1);
        chk("R7 pause cleared", int'(tx_pause), 0);
        pop("R7 data kept", 8'h41, 0, 0, 0);
        chk("R7 xon not queued", int'(rx_level), 0);
        send(8'h13, 0, 0);
        chk("R7 errored xoff ignored", int'(tx_pause), 0);
        pop("R7 errored xoff queued", 8'h13, 0, 1, 0);
        cfg_xon1 = 8'h13;
        send(8'h13, 0, 1);
        chk("R7 xoff wins", int'(tx_pause), 1);
        cfg_xon1 = 8'h11;
        send(8'h11, 0, 1);
        chk("R7 clear again", int'(tx_pause), 0);
    endtask

    task automatic t_double();
        cfg_flow_en = 1'b1; cfg_pair = 1'b1;
        send(8'h13, 0, 1);
        send(8'h93, 0, 1);
        chk("R8 pair pause", int'(tx_pause), 1);
        chk("R8 pair not queued", int'(rx_level), 0);
        send(8'h13, 0, 1);
        send(8'h41, 0, 1);
        chk("R8 broken pair level", int'(rx_level), 2);
        pop("R8 held flushed", 8'h13, 0, 0, 0);
        pop("R8 breaker kept", 8'h41, 0, 0, 0);
        send(8'h11, 0, 1);
        send(8'h11, 0, 1);
        send(8'h91, 0, 1);
        chk("R8 restart resume", int'(tx_pause), 0);
        chk("R8 restart level", int'(rx_level), 1);
        pop("R8 first xon1 flushed", 8'h11, 0, 0, 0);
        cfg_pair = 1'b0;
    endtask

    task automatic t_special();
        int s0;
        cfg_flow_en = 1'b0;
        s0 = n_special;
        send(8'h7E, 0, 1);
        chk("R9 special pulse", n_special - s0, 1);
        pop("R9 special queued", 8'h7E, 0, 0, 0);
        send(8'h7F, 0, 1);
        chk("R9 non-special", n_special - s0, 1);
        pop("R9 other queued", 8'h7F, 0, 0, 0);
    endtask

    task automatic t_flow_off();
        cfg_flow_en = 1'b1;
        send(8'h13, 0, 1);
        chk("R10 setup pause", int'(tx_pause), 1);
        cfg_flow_en = 1'b0;
        send(8'h11, 0, 1);
        chk("R10 pause unchanged", int'(tx_pause), 1);
        pop("R10 xon queued", 8'h11, 0, 0, 0);
        cfg_flow_en = 1'b1;
        send(8'h11, 0, 1);
        chk("R10 cleared after", int'(tx_pause), 0);
        cfg_flow_en = 1'b0;
    endtask

    task automatic t_disabled();
        @(negedge clk);
        rx_en = 1'b0;
        send(8'h55, 0, 1);
        chk("R11 nothing queued", int'(rx_level), 0);
        @(negedge clk);
        rx_en = 1'b1;
        idle(4);
        send(8'h56, 0, 1);
        pop("R11 enabled again", 8'h56, 0, 0, 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH + 2; i++) send(8'(i + 8'h20), 0, 1);
        chk("R12 full level", int'(rx_level), DEPTH);
        for (int i = 0; i < DEPTH; i++) pop("R12 drain", 8'(i + 8'h20), 0, 0, 0);
        chk("R12 empty after drain", int'(rx_empty), 1);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        idle(2);
        chk("R12 empty read ignored", int'(rx_level), 0);
    endtask

    initial begin
        fork
            begin
                idle(4);
                rst = 1'b0;
                idle(2);
                t_reset();
                t_frames();
                t_ferr();
                t_glitch();
                t_break();
                t_single();
                t_double();
                t_special();
                t_flow_off();
                t_disabled();
                t_overflow();
            end
            begin
                wait (cycles >= 150000);
                n_checks++;
                n_bad++;
                $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule